// File: doc/BRIEF.md
# S/PDIF Channel-Status and User-Data Sequencer

This block provides the channel-status bit (C) and the user-data bit (U) for each subframe of an S/PDIF-style transmit stream. It keeps four 192-bit register files: left C, right C, left U and right U. Each file is six 32-bit words that a simple register port writes and reads. A slot sequencer walks through the 192 frames of a block, two subframes per frame. On every subframe strobe it picks out the bit that belongs to the current slot.

The storage is live and has no shadow copy. A write lands at once in the words that feed the line encoder. Software times its updates with two aids. It can read the slot counter to find out which word is in use, and it can wait for the last-slot pulse, which marks a safe moment to rewrite words early in the block. Every slot is active, so every strobe produces a C/U pair.

The sequencer is a two-state machine, SUB_LEFT and SUB_RIGHT, plus a frame counter. A strobe in SUB_LEFT moves to SUB_RIGHT (transition LEFT_TO_RIGHT). A strobe in SUB_RIGHT moves back to SUB_LEFT and advances the frame (transition RIGHT_TO_LEFT). When that advance leaves frame 191, the frame count returns to 0 (transition BLOCK_WRAP). Without a strobe the machine holds its state (transition HOLD).

Top module: `spdif_cu_seq`

## Requirements
- R1: A block holds 192 frames, numbered 0 to 191. After the right subframe of frame 191, the next slot is frame 0, left.
- R2: Subframes alternate left and right, starting from left after reset. Each `sf_strobe` produces a one-cycle `cu_valid` on the following cycle, and `sf_right` shows 0 for left and 1 for right. Without a strobe, the slot does not change.
- R3: Frame n takes its bit from word n/32 at bit position n mod 32. Left subframes read the left-C and left-U files. Right subframes read the right-C and right-U files.
- R4: A write to any word takes effect immediately. A slot that reaches that word after the write uses the new value.
- R5: The register address `reg_addr[5:3]` selects the file: 0 is left C, 1 is right C, 2 is left U, 3 is right U. `reg_addr[2:0]` selects the word, 0 to 5. Writes to any other address are ignored, and reads of any other address return 0, except the counter address.
- R6: `blk_start` is high together with `cu_valid` only for the slot frame 0, left.
- R7: `last_slot` is high together with `cu_valid` only for the slot frame 191, right.
- R8: A read of address 0x20 returns the next slot to be encoded. Bit 0 holds the subframe (1 = right) and bits 8:1 hold the frame number. All other bits are 0.
- R9: After reset, all words are 0, the slot is frame 0 left, and `cu_valid`, `blk_start` and `last_slot` are 0.
- R10: `reg_rdata` is updated on the clock edge at which `reg_re` is high, and it holds its value when `reg_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_strobe | input | 1 | Request C/U for the current subframe and advance the slot |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_addr | input | 6 | Register word address (file code, word index) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_re` |
| cu_valid | output | 1 | C/U output pulse for one subframe |
| c_bit | output | 1 | Channel-status bit of the subframe |
| u_bit | output | 1 | User-data bit of the subframe |
| sf_right | output | 1 | Subframe identity (0 = left, 1 = right) |
| blk_start | output | 1 | First slot of the block |
| last_slot | output | 1 | Last slot of the block |

## Verification
The hardest case to reach is a live update while the sequencer runs. The new word must show up on the line, and neighbouring words and the slot position must stay undisturbed. The stimulus runs one full block to reach the wrap point. It then rewrites the last word of every file while the slot sits at frame 0, and it sends writes to unmapped addresses in the same window. A second full block follows, and the scoreboard compares every one of its 384 subframes against a model that holds the updated words.

// File: rtl/spdif_cu_pkg.sv
package spdif_cu_pkg;

    // Subframe phase of the slot sequencer
    typedef enum logic {
        SUB_LEFT  = 1'b0,
        SUB_RIGHT = 1'b1
    } sub_state_e;

    // File codes carried in the upper address bits
    typedef enum logic [2:0] {
        FSEL_LC  = 3'd0,
        FSEL_RC  = 3'd1,
        FSEL_LU  = 3'd2,
        FSEL_RU  = 3'd3,
        FSEL_CNT = 3'd4
    } fsel_e;

    localparam int unsigned FILE_CNT = 4;

endpackage

// File: rtl/spdif_cu_slot_fsm.sv
module spdif_cu_slot_fsm
    import spdif_cu_pkg::*;
#(
    parameter int unsigned FRAMES  = 192,
    parameter int unsigned FRAME_W = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    output logic [FRAME_W-1:0] frame,
    output logic               right,
    output logic               at_first,
    output logic               at_last
);

    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES - 1);

    sub_state_e         state, state_nxt;
    logic [FRAME_W-1:0] frame_q, frame_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SUB_LEFT;
            frame_q <= '0;
        end else begin
            state   <= state_nxt;
            frame_q <= frame_nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nxt = state;
        frame_nxt = frame_q;
        unique case (state)
            SUB_LEFT: begin
                if (step) begin
                    state_nxt = SUB_RIGHT;              // LEFT_TO_RIGHT
                end
            end
            SUB_RIGHT: begin
                if (step) begin
                    state_nxt = SUB_LEFT;               // RIGHT_TO_LEFT
                    if (frame_q == LAST_FRAME) begin
                        frame_nxt = '0;                 // BLOCK_WRAP
                    end else begin
                        frame_nxt = frame_q + 1'b1;
                    end
                end
            end
        endcase
    end

    assign frame    = frame_q;
    assign right    = (state == SUB_RIGHT);
    assign at_first = (state == SUB_LEFT)  && (frame_q == '0);
    assign at_last  = (state == SUB_RIGHT) && (frame_q == LAST_FRAME);

    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q <= LAST_FRAME);                                           // R1
    AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state == SUB_RIGHT && frame_q == LAST_FRAME)
        |=> (frame_q == '0 && state == SUB_LEFT));                        // R1
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (state != $past(state)));                                // R2
    AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(state) && $stable(frame_q)));                  // R2

endmodule

// File: rtl/spdif_cu_regfile.sv
module spdif_cu_regfile
    import spdif_cu_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned WORDS   = 6,
    parameter int unsigned FRAME_W = 8,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [FRAME_W-1:0] frame,
    input  logic               right,
    output logic               c_tap,
    output logic               u_tap,
    output logic [WORD_W-1:0]  rd_word
);

    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam int unsigned IDX_W = 3;

    logic [2:0]        fsel;
    logic [IDX_W-1:0]  widx;
    logic              widx_ok;
    logic [IDX_W-1:0]  tap_word;
    logic [BIT_W-1:0]  tap_bit;
    logic [FILE_CNT-1:0] tap;
    logic [WORD_W-1:0] file_rd [FILE_CNT];

    assign fsel     = addr[ADDR_W-1 -: 3];
    assign widx     = addr[IDX_W-1:0];
    assign widx_ok  = (32'(widx) < WORDS);
    assign tap_word = IDX_W'(frame >> BIT_W);
    assign tap_bit  = frame[BIT_W-1:0];

    for (genvar gf = 0; gf < FILE_CNT; gf++) begin : g_file
        logic [WORD_W-1:0] words [WORDS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WORDS; i++) begin
                    words[i] <= '0;
                end
            end else if (we && widx_ok && (fsel == 3'(gf))) begin
                words[widx] <= wdata;
            end
        end

        assign file_rd[gf] = widx_ok ? words[widx] : '0;
        assign tap[gf]     = words[tap_word][tap_bit];
    end

    always_comb begin
        rd_word = '0;
        unique case (fsel)
            FSEL_LC: rd_word = file_rd[0];
            FSEL_RC: rd_word = file_rd[1];
            FSEL_LU: rd_word = file_rd[2];
            FSEL_RU: rd_word = file_rd[3];
            default: rd_word = '0;
        endcase
    end

    assign c_tap = right ? tap[FSEL_RC] : tap[FSEL_LC];
    assign u_tap = right ? tap[FSEL_RU] : tap[FSEL_LU];

    AST_BAD_FILE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel > 3'd3) |-> (rd_word == '0));                               // R5

endmodule

// File: rtl/spdif_cu_seq.sv
module spdif_cu_seq
    import spdif_cu_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 6,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sf_strobe,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              cu_valid,
    output logic              c_bit,
    output logic              u_bit,
    output logic              sf_right,
    output logic              blk_start,
    output logic              last_slot
);

    localparam int unsigned FRAMES  = WORD_W * WORDS;
    localparam int unsigned FRAME_W = $clog2(FRAMES);
    localparam logic [ADDR_W-1:0] CNT_ADDR = {FSEL_CNT, {(ADDR_W-3){1'b0}}};

    logic [FRAME_W-1:0] slot_frame;
    logic               slot_right;
    logic               slot_first;
    logic               slot_last;
    logic               c_tap;
    logic               u_tap;
    logic [WORD_W-1:0]  rd_word;
    logic [WORD_W-1:0]  cnt_word;

    spdif_cu_slot_fsm #(
        .FRAMES  (FRAMES),
        .FRAME_W (FRAME_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (sf_strobe),
        .frame    (slot_frame),
        .right    (slot_right),
        .at_first (slot_first),
        .at_last  (slot_last)
    );

    spdif_cu_regfile #(
        .WORD_W  (WORD_W),
        .WORDS   (WORDS),
        .FRAME_W (FRAME_W),
        .ADDR_W  (ADDR_W)
    ) u_files (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .frame   (slot_frame),
        .right   (slot_right),
        .c_tap   (c_tap),
        .u_tap   (u_tap),
        .rd_word (rd_word)
    );

    assign cnt_word = WORD_W'({slot_frame, slot_right});

    // Subframe output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cu_valid  <= 1'b0;
            c_bit     <= 1'b0;
            u_bit     <= 1'b0;
            sf_right  <= 1'b0;
            blk_start <= 1'b0;
            last_slot <= 1'b0;
        end else begin
            cu_valid  <= sf_strobe;
            blk_start <= sf_strobe && slot_first;
            last_slot <= sf_strobe && slot_last;
            if (sf_strobe) begin
                c_bit    <= c_tap;
                u_bit    <= u_tap;
                sf_right <= slot_right;
            end
        end
    end

    // Register read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            reg_rdata <= (reg_addr == CNT_ADDR) ? cnt_word : rd_word;
        end
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sf_strobe |=> cu_valid);                                          // R2
    AST_BLK_START_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |-> (cu_valid && !sf_right));                           // R6
    AST_LAST_SLOT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        last_slot |-> (cu_valid && sf_right));                            // R7
    AST_LAST_THEN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        last_slot |-> (slot_frame == '0 && !slot_right));                 // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));                                  // R10

endmodule

// File: tb/spdif_cu_seq_test.sv
module spdif_cu_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sf_strobe = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cu_valid, c_bit, u_bit, sf_right, blk_start, last_slot;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] model [4][6];
    logic [4:0]  sb_q [$];
    int          m_frame = 0;
    int          m_right = 0;

    always #5 clk = ~clk;

    spdif_cu_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sf_strobe (sf_strobe),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cu_valid  (cu_valid),
        .c_bit     (c_bit),
        .u_bit     (u_bit),
        .sf_right  (sf_right),
        .blk_start (blk_start),
        .last_slot (last_slot)
    );

    function automatic logic [31:0] pat(int f, int w);
        return 32'h9E37_79B9 * 32'(f * 8 + w + 1) ^ 32'(w * 32'h0101_0101);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    // Driver: predict the subframe outputs, then strobe
    task automatic strobe_once();
        logic c, u;
        int   w, b;
        w = m_frame / 32;
        b = m_frame % 32;
        c = model[m_right ? 1 : 0][w][b];
        u = model[m_right ? 3 : 2][w][b];
        sb_q.push_back({c, u, 1'(m_right), 1'(m_frame == 0 && m_right == 0),
                        1'(m_frame == 191 && m_right == 1)});
        @(negedge clk);
        sf_strobe = 1'b1;
        @(negedge clk);
        sf_strobe = 1'b0;
        if (m_right == 1) begin
            m_right = 0;
            m_frame = (m_frame == 191) ? 0 : m_frame + 1;
        end else begin
            m_right = 1;
        end
    endtask

    // Monitor: compare each produced subframe against the scoreboard
    always @(negedge clk) begin
        if (rst_n && cu_valid) begin
            if (sb_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R2 actual=unexpected cu_valid expected=none");
            end else begin
                logic [4:0] exp;
                exp = sb_q.pop_front();
                chk("R3 R2 R6 R7 subframe {c,u,right,blk,last}",
                    32'({c_bit, u_bit, sf_right, blk_start, last_slot}), 32'(exp));
            end
        end
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int f = 0; f < 4; f++) begin
            for (int w = 0; w < 6; w++) begin
                model[f][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 cu_valid after reset", 32'(cu_valid), 0);
        chk("R9 blk_start/last_slot after reset", 32'({blk_start, last_slot}), 0);
        rd(6'h20, d);
        chk("R9 R8 counter after reset", d, 0);
        rd(6'h00, d);
        chk("R9 word left-C 0 after reset", d, 0);

        // R5, R10: fill all files and read back
        for (int f = 0; f < 4; f++) begin
            for (int w = 0; w < 6; w++) begin
                wr(6'(f * 8 + w), pat(f, w));
                model[f][w] = pat(f, w);
            end
        end
        for (int f = 0; f < 4; f++) begin
            for (int w = 0; w < 6; w++) begin
                rd(6'(f * 8 + w), d);
                chk("R5 R10 readback", d, pat(f, w));
            end
        end
        // R10: rdata holds while reg_re is low
        repeat (3) @(negedge clk);
        chk("R10 rdata held", reg_rdata, pat(3, 5));

        // First block: R1 R2 R3 R6 R7, counter reads mid-block R8
        for (int k = 0; k < 384; k++) begin
            if (k == 100 || k == 101 || k == 383) begin
                rd(6'h20, d);
                chk("R8 counter mid-block", d, 32'(k));
            end
            strobe_once();
        end
        repeat (2) @(negedge clk);
        rd(6'h20, d);
        chk("R1 counter wraps to frame 0 left", d, 0);

        // R4: live update of the last word of each file while at frame 0
        for (int f = 0; f < 4; f++) begin
            wr(6'(f * 8 + 5), ~pat(f, 5));
            model[f][5] = ~pat(f, 5);
        end
        // R5: writes to unmapped addresses are ignored
        wr(6'h06, 32'hDEAD_BEEF);
        wr(6'h28, 32'hDEAD_BEEF);
        wr(6'h21, 32'hDEAD_BEEF);
        wr(6'h20, 32'hDEAD_BEEF);
        rd(6'h06, d);
        chk("R5 unmapped word reads 0", d, 0);
        rd(6'h28, d);
        chk("R5 unmapped file reads 0", d, 0);
        rd(6'h00, d);
        chk("R5 left-C word 0 untouched", d, pat(0, 0));
        rd(6'h20, d);
        chk("R5 R8 counter unaffected by write", d, 0);
        rd(6'h1D, d);
        chk("R4 right-U word 5 updated", d, ~pat(3, 5));

        // Second block uses the updated words (R4)
        for (int k = 0; k < 384; k++) begin
            strobe_once();
        end
        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", 32'(sb_q.size()), 0);
        rd(6'h20, d);
        chk("R1 counter after second block", d, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule